// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port

This block is the I/O port of a very small 8-bit controller. It has four pins. The CPU side has three single-cycle strobes. One writes the output latches. One reads the port. One loads the direction register, which cannot be read back. A port read returns the live levels on the pins, not what the latches hold. The upper four bits of the 8-bit read value are always zero. Pin 3 is an input only, and its driver is never enabled.

Around the plain port logic sit several shared features:
- one enable for weak pull-ups;
- one enable for wake-on-change;
- a master-clear option that takes over pin 3;
- a fixed priority by which comparator, clock-divide output and timer-clock functions claim pins ahead of the port.

Wake-on-change compares the watched pins against a snapshot taken at the most recent port read. Any difference sets a sticky flag, and only reset clears that flag. The external reset is asserted asynchronously and released synchronously inside the block.

Top module: `mcu_gpio_port`

## Requirements
- R1: While reset is held and after its release, before any strobe: `pin_oe` is 0000 and `wake_flag` is 0. The output latches reset to 0 and every direction bit resets to 1.
- R2: While `data_rd` is high, `rdata[3:0]` equals the live `pin_in` and `rdata[7:4]` is zero. While `data_rd` is low, `rdata` is zero.
- R3: `pin_oe[3]` is never 1, whatever has been written to the latch or direction register.
- R4: For a port-owned pin 0, 1 or 2, direction bit 0 gives `pin_oe`=1 with `pin_out` equal to that pin's latch bit. Direction bit 1 gives `pin_oe`=0.
- R5: A `data_wr` updates the latches even for pins set as inputs. The written value shows on the pin once its direction bit is cleared.
- R6: A `tris_ld` changes no value returned by a read; reads still report `pin_in`.
- R7: When `pu_en`=1, `pin_pu` is 1 on pins 0, 1 and 3. `pin_pu[2]` is always 0. `mclr_en`=1 forces `pin_pu[3]` to 1 even when `pu_en`=0.
- R8: With `wake_en`=1, a difference on pin 0, 1 or 3 between `pin_in` and the snapshot from the last read, in a cycle without a read, sets `wake_flag` at the next clock. The flag then stays 1 until reset. Pin 2 is never watched.
- R9: With `mclr_en`=1, pin 3 is not watched for wake. In that case `mclr_req` equals the inverse of `pin_in[3]`; otherwise `mclr_req` is 0.
- R10: With `cmp_en`=1, pins 0 and 1 are undriven. In that case `cmp_pos`=`pin_in[0]` and `cmp_neg`=`pin_in[1]`; otherwise both are 0.
- R11: Pin 2 goes to the first enabled claimant in this order:
  - `clk4_en`, which drives `clk4_val`;
  - `cmp_out_en`, which drives `cmp_out`;
  - `tmr_ext_en`, which leaves the pin undriven and gives `tmr_clk`=`pin_in[2]`;
  - the port.
  
  `tmr_clk` is 0 unless the timer owns the pin.
- R12: A pin driven high by the port but held low outside reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr | input | 1 | Output latch write strobe |
| data_rd | input | 1 | Port read strobe |
| tris_ld | input | 1 | Direction register load strobe |
| wdata | input | 4 | Value for latch or direction load |
| rdata | output | 8 | Read value, live pin levels in low nibble |
| pin_in | input | 4 | Sampled pin levels |
| pin_out | output | 4 | Output value per pin |
| pin_oe | output | 4 | Output driver enable per pin |
| pin_pu | output | 4 | Weak pull-up enable per pin |
| pu_en | input | 1 | Shared pull-up enable |
| wake_en | input | 1 | Shared wake-on-change enable |
| mclr_en | input | 1 | Pin 3 acts as master-clear |
| cmp_en | input | 1 | Comparator takes pins 0 and 1 |
| cmp_out_en | input | 1 | Comparator output requests pin 2 |
| cmp_out | input | 1 | Comparator output value |
| clk4_en | input | 1 | Clock/4 output requests pin 2 |
| clk4_val | input | 1 | Clock/4 output value |
| tmr_ext_en | input | 1 | Timer clock input requests pin 2 |
| wake_flag | output | 1 | Sticky wake-on-change flag |
| mclr_req | output | 1 | Master-clear request |
| cmp_pos | output | 1 | Comparator positive input |
| cmp_neg | output | 1 | Comparator negative input |
| tmr_clk | output | 1 | Timer external clock |

## Verification
The hardest situation to reach is a wake event that must be told apart from a harmless change. The flag must not rise for a read, for a change on pin 2, or for pin 3 while it serves as master-clear. It must rise for a change on pin 0 or 3 against an older snapshot. The stimulus first takes a snapshot with a read, then enables wake, then moves the unwatched pins, and checks that the flag stays low. Only then does it move a watched pin and check that the flag stays set after the pin returns. A second pass repeats this with master-clear on and then off.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Fixed pin roles; the ownership priority depends on these positions.
  localparam int PIN_CMP_POS = 0;
  localparam int PIN_CMP_NEG = 1;
  localparam int PIN_SHARED  = 2;
  localparam int PIN_INONLY  = 3;

  typedef enum logic [2:0] {
    OWN_PORT,
    OWN_CMP_IN,
    OWN_CLK4,
    OWN_CMP_OUT,
    OWN_TMR_IN,
    OWN_MCLR
  } pin_owner_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             ld_stb,
  input  logic [NPINS-1:0] wval,
  output logic [NPINS-1:0] lat_q,
  output logic [NPINS-1:0] dir_q
);
  logic [NPINS-1:0] lat_d;
  logic [NPINS-1:0] dir_d;

  always_comb begin
    lat_d = lat_q;
    dir_d = dir_q;
    if (wr_stb) lat_d = wval;
    if (ld_stb) dir_d = wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      if (wr_stb) lat_q <= lat_d;
      if (ld_stb) dir_q <= dir_d;
    end
  end

  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_stb |=> $stable(dir_q)); // R6
  AST_LAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(lat_q)); // R5
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lat_q,
  input  logic [NPINS-1:0] dir_q,
  input  logic             cmp_en,
  input  logic             cmp_out_en,
  input  logic             cmp_out,
  input  logic             clk4_en,
  input  logic             clk4_val,
  input  logic             tmr_ext_en,
  input  logic             mclr_en,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             tmr_owns
);
  localparam logic [NPINS-1:0] DRIVE_CAP = ~(NPINS'(1) << PIN_INONLY);

  pin_owner_e owner [NPINS];

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    if (g == PIN_CMP_POS || g == PIN_CMP_NEG) begin : g_cmp_in
      always_comb owner[g] = cmp_en ? OWN_CMP_IN : OWN_PORT;
    end else if (g == PIN_SHARED) begin : g_shared
      always_comb begin
        if (clk4_en)         owner[g] = OWN_CLK4;
        else if (cmp_out_en) owner[g] = OWN_CMP_OUT;
        else if (tmr_ext_en) owner[g] = OWN_TMR_IN;
        else                 owner[g] = OWN_PORT;
      end
    end else if (g == PIN_INONLY) begin : g_inonly
      always_comb owner[g] = mclr_en ? OWN_MCLR : OWN_PORT;
    end else begin : g_plain
      always_comb owner[g] = OWN_PORT;
    end

    always_comb begin
      case (owner[g])
        OWN_CLK4:    begin pin_out[g] = clk4_val; pin_oe[g] = 1'b1; end
        OWN_CMP_OUT: begin pin_out[g] = cmp_out;  pin_oe[g] = 1'b1; end
        OWN_PORT:    begin
          pin_out[g] = lat_q[g];
          pin_oe[g]  = ~dir_q[g] & DRIVE_CAP[g];
        end
        default:     begin pin_out[g] = 1'b0; pin_oe[g] = 1'b0; end
      endcase
    end
  end

  assign tmr_owns = (owner[PIN_SHARED] == OWN_TMR_IN);

  AST_CLK4_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clk4_en |-> (pin_oe[PIN_SHARED] && pin_out[PIN_SHARED] == clk4_val)); // R11
  AST_CMP_IN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |-> (pin_oe[PIN_CMP_POS] == 1'b0 && pin_oe[PIN_CMP_NEG] == 1'b0)); // R10
endmodule

// File: rtl/gpio_wake_det.sv
module gpio_wake_det
  import gpio_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic [NPINS-1:0] pin_in,
  input  logic             wake_en,
  input  logic             mclr_en,
  output logic             wake_flag
);
  localparam logic [NPINS-1:0] WATCH_CAP =
    (NPINS'(1) << PIN_CMP_POS) | (NPINS'(1) << PIN_CMP_NEG) | (NPINS'(1) << PIN_INONLY);
  localparam logic [NPINS-1:0] PIN3_BIT = NPINS'(1) << PIN_INONLY;

  logic [NPINS-1:0] snap_q, snap_d;
  logic             flag_q, flag_d;
  logic [NPINS-1:0] watch;
  logic             diff;

  always_comb begin
    watch  = wake_en ? (WATCH_CAP & ~(mclr_en ? PIN3_BIT : '0)) : '0;
    diff   = |((pin_in ^ snap_q) & watch);
    snap_d = rd_stb ? pin_in : snap_q;
    flag_d = flag_q | (diff & ~rd_stb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (rd_stb) snap_q <= snap_d;
      flag_q <= flag_d;
    end
  end

  assign wake_flag = flag_q;

  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wake_flag |=> wake_flag); // R8
  AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_flag && !wake_en) |=> !wake_flag); // R8
endmodule

// File: rtl/mcu_gpio_port.sv
module mcu_gpio_port
  import gpio_pkg::*;
#(
  parameter int NPINS = 4,
  parameter int DW    = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic             data_rd,
  input  logic             tris_ld,
  input  logic [NPINS-1:0] wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_pu,
  input  logic             pu_en,
  input  logic             wake_en,
  input  logic             mclr_en,
  input  logic             cmp_en,
  input  logic             cmp_out_en,
  input  logic             cmp_out,
  input  logic             clk4_en,
  input  logic             clk4_val,
  input  logic             tmr_ext_en,
  output logic             wake_flag,
  output logic             mclr_req,
  output logic             cmp_pos,
  output logic             cmp_neg,
  output logic             tmr_clk
);
  localparam int PAD = DW - NPINS;
  localparam logic [NPINS-1:0] PU_CAP =
    (NPINS'(1) << PIN_CMP_POS) | (NPINS'(1) << PIN_CMP_NEG) | (NPINS'(1) << PIN_INONLY);
  localparam logic [NPINS-1:0] PIN3_BIT = NPINS'(1) << PIN_INONLY;

  logic             rst_ni;
  logic [NPINS-1:0] lat_q, dir_q;
  logic             tmr_owns;

  gpio_rst_sync #(.STAGES(SYNC)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni)
  );

  gpio_port_regs #(.NPINS(NPINS)) i_regs (
    .clk(clk), .rst_n(rst_ni), .wr_stb(data_wr), .ld_stb(tris_ld),
    .wval(wdata), .lat_q(lat_q), .dir_q(dir_q)
  );

  gpio_pin_mux #(.NPINS(NPINS)) i_mux (
    .clk(clk), .rst_n(rst_ni), .lat_q(lat_q), .dir_q(dir_q),
    .cmp_en(cmp_en), .cmp_out_en(cmp_out_en), .cmp_out(cmp_out),
    .clk4_en(clk4_en), .clk4_val(clk4_val), .tmr_ext_en(tmr_ext_en),
    .mclr_en(mclr_en), .pin_out(pin_out), .pin_oe(pin_oe), .tmr_owns(tmr_owns)
  );

  gpio_wake_det #(.NPINS(NPINS)) i_wake (
    .clk(clk), .rst_n(rst_ni), .rd_stb(data_rd), .pin_in(pin_in),
    .wake_en(wake_en), .mclr_en(mclr_en), .wake_flag(wake_flag)
  );

  always_comb begin
    rdata    = data_rd ? {{PAD{1'b0}}, pin_in} : '0;
    pin_pu   = (pu_en ? PU_CAP : '0) | (mclr_en ? PIN3_BIT : '0);
    mclr_req = mclr_en & ~pin_in[PIN_INONLY];
    cmp_pos  = cmp_en & pin_in[PIN_CMP_POS];
    cmp_neg  = cmp_en & pin_in[PIN_CMP_NEG];
    tmr_clk  = tmr_owns & pin_in[PIN_SHARED];
  end

  AST_PIN3_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (!rst_ni)
    !pin_oe[PIN_INONLY]); // R3
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    rdata[DW-1:NPINS] == '0); // R2
  AST_MCLR_PULLUP: assert property (@(posedge clk) disable iff (!rst_ni)
    mclr_en |-> pin_pu[PIN_INONLY]); // R7
  AST_NO_SHARED_PULLUP: assert property (@(posedge clk) disable iff (!rst_ni)
    !pin_pu[PIN_SHARED]); // R7
endmodule

// File: tb/test_mcu_gpio_port.sv
module test_mcu_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       data_wr, data_rd, tris_ld;
  logic [3:0] wdata, pin_in;
  logic [7:0] rdata;
  logic [3:0] pin_out, pin_oe, pin_pu;
  logic       pu_en, wake_en, mclr_en, cmp_en, cmp_out_en, cmp_out;
  logic       clk4_en, clk4_val, tmr_ext_en;
  logic       wake_flag, mclr_req, cmp_pos, cmp_neg, tmr_clk;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  mcu_gpio_port i_mcu_gpio_port (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_rd(data_rd),
    .tris_ld(tris_ld), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pu_en(pu_en),
    .wake_en(wake_en), .mclr_en(mclr_en), .cmp_en(cmp_en),
    .cmp_out_en(cmp_out_en), .cmp_out(cmp_out), .clk4_en(clk4_en),
    .clk4_val(clk4_val), .tmr_ext_en(tmr_ext_en), .wake_flag(wake_flag),
    .mclr_req(mclr_req), .cmp_pos(cmp_pos), .cmp_neg(cmp_neg), .tmr_clk(tmr_clk)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    data_wr = 0; data_rd = 0; tris_ld = 0; wdata = 0; pin_in = 0;
    pu_en = 0; wake_en = 0; mclr_en = 0; cmp_en = 0; cmp_out_en = 0;
    cmp_out = 0; clk4_en = 0; clk4_val = 0; tmr_ext_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 oe in reset", {4'h0, pin_oe}, 8'h00);
    chk("R1 wake in reset", {7'h0, wake_flag}, 8'h00);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_lat(input logic [3:0] v);
    wdata = v; data_wr = 1; @(negedge clk); data_wr = 0;
  endtask

  task automatic ld_dir(input logic [3:0] v);
    wdata = v; tris_ld = 1; @(negedge clk); tris_ld = 0;
  endtask

  task automatic rd_port(output logic [7:0] v);
    data_rd = 1; #1 v = rdata; @(negedge clk); data_rd = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    chk("R1 oe after reset", {4'h0, pin_oe}, 8'h00);
    chk("R1 wake after reset", {7'h0, wake_flag}, 8'h00);
    ld_dir(4'b0000); #1;
    chk("R1 latch reset value", {4'h0, pin_out}, 8'h00);
    ld_dir(4'b1111);
    pin_in = 4'b1010; #1;
    chk("R2 no read gives zero", rdata, 8'h00);
    rd_port(v);
    chk("R2 read live pins", v, 8'h0A);
  endtask

  task automatic t_drive();
    wr_lat(4'b1111);
    ld_dir(4'b1010); #1;
    chk("R4 oe per dir", {4'h0, pin_oe}, 8'h05);
    chk("R4 out follows latch", {4'h0, pin_out & pin_oe}, 8'h05);
    ld_dir(4'b0000); #1;
    chk("R3 pin3 undriven", {7'h0, pin_oe[3]}, 8'h00);
    chk("R4 all driven pins 0..2", {4'h0, pin_oe}, 8'h07);
  endtask

  task automatic t_latch_as_input();
    logic [7:0] v;
    ld_dir(4'b1111);
    wr_lat(4'b0101); #1;
    chk("R5 input stays undriven", {4'h0, pin_oe}, 8'h00);
    ld_dir(4'b1011); #1;
    chk("R5 value appears", {6'h0, pin_oe[2], pin_out[2]}, 8'h03);
    pin_in = 4'b0110;
    ld_dir(4'b0000);
    rd_port(v);
    chk("R6 read ignores dir load", v, 8'h06);
    pin_in = 4'b0000; wr_lat(4'b0111);
    rd_port(v);
    chk("R12 contention reads pin", v, 8'h00);
  endtask

  task automatic t_pullup();
    pu_en = 1; #1;
    chk("R7 pullups shared", {4'h0, pin_pu}, 8'h0B);
    pu_en = 0; mclr_en = 1; pin_in = 4'b0000; #1;
    chk("R7 mclr forces pin3 pullup", {4'h0, pin_pu}, 8'h08);
    chk("R9 mclr request low pin", {7'h0, mclr_req}, 8'h01);
    pin_in = 4'b1000; #1;
    chk("R9 mclr request high pin", {7'h0, mclr_req}, 8'h00);
    mclr_en = 0; pin_in = 4'b0000; #1;
    chk("R9 mclr off", {7'h0, mclr_req}, 8'h00);
  endtask

  task automatic t_wake();
    logic [7:0] v;
    do_reset();
    pin_in = 4'b0000;
    rd_port(v);
    wake_en = 1;
    pin_in = 4'b0100;
    repeat (2) @(negedge clk);
    chk("R8 pin2 not watched", {7'h0, wake_flag}, 8'h00);
    pin_in = 4'b0101;
    rd_port(v);
    @(negedge clk);
    chk("R8 read resnaps", {7'h0, wake_flag}, 8'h00);
    pin_in = 4'b0100;
    @(negedge clk);
    chk("R8 change sets flag", {7'h0, wake_flag}, 8'h01);
    pin_in = 4'b0101; wake_en = 0;
    repeat (2) @(negedge clk);
    chk("R8 flag sticky", {7'h0, wake_flag}, 8'h01);
    do_reset();
    chk("R8 reset clears", {7'h0, wake_flag}, 8'h00);
    pin_in = 4'b0000;
    rd_port(v);
    mclr_en = 1; wake_en = 1;
    pin_in = 4'b1000;
    repeat (2) @(negedge clk);
    chk("R9 pin3 not watched under mclr", {7'h0, wake_flag}, 8'h00);
    mclr_en = 0;
    @(negedge clk);
    chk("R8 pin3 watched otherwise", {7'h0, wake_flag}, 8'h01);
    wake_en = 0; pin_in = 4'b0000;
  endtask

  task automatic t_alt();
    ld_dir(4'b0000); wr_lat(4'b0000);
    pin_in = 4'b0011; cmp_en = 1; #1;
    chk("R10 cmp pins undriven", {6'h0, pin_oe[1:0]}, 8'h00);
    chk("R10 cmp inputs", {6'h0, cmp_neg, cmp_pos}, 8'h03);
    cmp_en = 0; #1;
    chk("R10 cmp off", {6'h0, cmp_neg, cmp_pos}, 8'h00);
    pin_in = 4'b0100;
    tmr_ext_en = 1; #1;
    chk("R11 timer owns pin2", {6'h0, pin_oe[2], tmr_clk}, 8'h01);
    cmp_out_en = 1; cmp_out = 1; #1;
    chk("R11 cmp out over timer", {5'h0, pin_oe[2], pin_out[2], tmr_clk}, 8'h06);
    clk4_en = 1; clk4_val = 0; #1;
    chk("R11 clk4 highest", {6'h0, pin_oe[2], pin_out[2]}, 8'h02);
    clk4_en = 0; cmp_out_en = 0; tmr_ext_en = 0; #1;
    chk("R11 port regains pin2", {5'h0, pin_oe[2], pin_out[2], tmr_clk}, 8'h04);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    t_reset();
    t_drive();
    t_latch_as_input();
    t_pullup();
    t_wake();
    t_alt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule